// File: doc/BRIEF.md
# CCD Vertical Sweep Sequencer

This block clears residual charge out of a CCD's vertical shift register at high speed, typically right after the mechanical shutter has closed and before the stored image is read out. A single start pulse arms it. It waits for a fixed position within the next horizontal line, then takes over the vertical transfer outputs from the normal timing generator. It runs a burst of fast four-phase transfer steps that lasts many line periods, and at the end hands the outputs back.

Each transfer step walks through four overlapping phase states, and every state is held for a programmable number of pixel clocks. The number of steps is also programmable. The default setting, 758 steps with each state held for 14 clocks and starting at line clock 56, fills exactly 23 lines of 1848 clocks. Horizontal sync keeps running throughout the sweep. Vertical sync is blanked from the moment a sweep is accepted until it completes, and completion is flagged by a one-cycle done pulse.

Top module: `ccd_vsweep`

## Requirements
- R1: A start pulse seen while idle with a nonzero step count latches the step count and the step length and raises busy_o in the following cycle.
- R2: The line position is the number of clock edges since the edge that sampled hd_i high. The first sweep cycle is the first cycle after acceptance in which the line position equals START_POS (default 56). If that point of the current line has already passed, the sweep waits for the next line.
- R3: While sweeping, v_o bits are {v4, v3b, v3a, v2, v1b, v1a} (bit 5 down to bit 0), with v1a=v1b and v3a=v3b. The states cycle 6'b000111, 6'b011100, 6'b111000, 6'b100011 (phases 1+2, 2+3, 3+4, 4+1), so exactly two adjacent phases are high.
- R4: Each phase state is held for the latched step length in clocks. A step length of zero is treated as one clock.
- R5: A sweep lasts step count x 4 x step length clocks. In the next cycle done_o is high for exactly one cycle and busy_o is already low. At the defaults with 1848-clock lines, done_o lands at line position 0.
- R6: A start pulse while busy_o is high, including the last sweep cycle, is ignored: busy stays high and the running sequence is unchanged.
- R7: vd_o follows vd_i while idle and is held low while busy_o is high.
- R8: Whenever no sweep is driving, including the wait for the line position, v_o equals norm_v_i.
- R9: A start pulse with a step count of zero is ignored and busy_o stays low.
- R10: A start pulse in the same cycle as done_o is accepted as a new sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hd_i | input | 1 | Horizontal sync pulse, one cycle per line |
| vd_i | input | 1 | Vertical sync from the normal timing generator |
| start_i | input | 1 | Sweep request pulse |
| step_cnt_i | input | CNT_W | Number of transfer steps |
| step_len_i | input | LEN_W | Clocks per phase state |
| norm_v_i | input | 6 | Normal vertical phases {v4,v3b,v3a,v2,v1b,v1a} |
| v_o | output | 6 | Vertical phases to the drivers, same bit order |
| vd_o | output | 1 | Vertical sync, blanked while busy |
| busy_o | output | 1 | Sweep accepted or running |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The end of one sweep and a new request can fall in adjacent cycles or in the same cycle. The bench drives a start on the final sweep cycle, with a different configuration, and then another start in the cycle where done_o pulses. The scoreboard holds only the expected phase states of the second request. A design that honoured the first start, or lost the second, produces a phase sequence or length that does not match the queue.

// File: rtl/ccd_vsweep_pkg.sv
package ccd_vsweep_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_WAIT, ST_RUN} sweep_state_e;

  // bit order {v4, v3b, v3a, v2, v1b, v1a}
  function automatic logic [5:0] phase_pat(input logic [1:0] sub);
    case (sub)
      2'd0:    phase_pat = 6'b000111;
      2'd1:    phase_pat = 6'b011100;
      2'd2:    phase_pat = 6'b111000;
      default: phase_pat = 6'b100011;
    endcase
  endfunction
endpackage

// File: rtl/ccd_vsweep_linepos.sv
module ccd_vsweep_linepos #(
  parameter int LINE_W    = 11,
  parameter int START_POS = 56
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hd_i,
  output logic arm_o
);
  localparam logic [LINE_W-1:0] ArmPos = LINE_W'(START_POS - 1);

  logic [LINE_W-1:0] hpos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             hpos_q <= '1;
    else if (hd_i)           hpos_q <= '0;
    else if (hpos_q != '1)   hpos_q <= hpos_q + 1'b1;
  end

  // one cycle ahead so the first sweep cycle sits at START_POS
  assign arm_o = (hpos_q == ArmPos);
endmodule

// File: rtl/ccd_vsweep_stepper.sv
module ccd_vsweep_stepper #(
  parameter int CNT_W = 10,
  parameter int LEN_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             run_o,
  output logic [1:0]       sub_o,
  output logic [LEN_W-1:0] len_pos_o,
  output logic             fin_o
);
  logic             run_q;
  logic [1:0]       sub_q;
  logic [LEN_W-1:0] len_q;
  logic [CNT_W-1:0] step_q;
  logic             sub_end;

  assign sub_end = (len_q == len_i - LEN_W'(1));
  assign fin_o   = run_q && sub_end && (sub_q == 2'd3) && (step_q == cnt_i - CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      sub_q  <= '0;
      len_q  <= '0;
      step_q <= '0;
    end else if (go_i) begin
      run_q  <= 1'b1;
      sub_q  <= '0;
      len_q  <= '0;
      step_q <= '0;
    end else if (run_q) begin
      if (sub_end) begin
        len_q <= '0;
        sub_q <= sub_q + 1'b1;
        if (sub_q == 2'd3) step_q <= step_q + 1'b1;
      end else begin
        len_q <= len_q + 1'b1;
      end
      if (fin_o) run_q <= 1'b0;
    end
  end

  assign run_o     = run_q;
  assign sub_o     = sub_q;
  assign len_pos_o = len_q;
endmodule

// File: rtl/ccd_vsweep.sv
module ccd_vsweep
  import ccd_vsweep_pkg::*;
#(
  parameter int CNT_W     = 10,
  parameter int LEN_W     = 6,
  parameter int LINE_W    = 11,
  parameter int START_POS = 56
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hd_i,
  input  logic             vd_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] step_cnt_i,
  input  logic [LEN_W-1:0] step_len_i,
  input  logic [5:0]       norm_v_i,
  output logic [5:0]       v_o,
  output logic             vd_o,
  output logic             busy_o,
  output logic             done_o
);
  sweep_state_e     state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [LEN_W-1:0] len_q;
  logic             done_q;
  logic             arm_w, go_w, run_w, fin_w;
  logic [1:0]       sub_w;
  logic [LEN_W-1:0] len_pos_w;

  ccd_vsweep_linepos #(.LINE_W(LINE_W), .START_POS(START_POS)) u_linepos (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .hd_i  (hd_i),
    .arm_o (arm_w)
  );

  assign go_w = (state_q == ST_WAIT) && arm_w;

  ccd_vsweep_stepper #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_stepper (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (go_w),
    .cnt_i    (cnt_q),
    .len_i    (len_q),
    .run_o    (run_w),
    .sub_o    (sub_w),
    .len_pos_o(len_pos_w),
    .fin_o    (fin_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= LEN_W'(1);
      done_q  <= 1'b0;
    end else begin
      done_q <= fin_w;
      case (state_q)
        ST_IDLE: if (start_i && step_cnt_i != '0) begin
          cnt_q   <= step_cnt_i;
          len_q   <= (step_len_i == '0) ? LEN_W'(1) : step_len_i;
          state_q <= ST_WAIT;
        end
        ST_WAIT: if (arm_w) state_q <= ST_RUN;
        default: if (fin_w) state_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
  assign vd_o   = vd_i & ~busy_o;
  assign v_o    = run_w ? phase_pat(sub_w) : norm_v_i;
endmodule

// File: rtl/ccd_vsweep_chk.sv
module ccd_vsweep_chk #(
  parameter int CNT_W = 10,
  parameter int LEN_W = 6
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic [CNT_W-1:0] step_cnt_i,
  input logic [5:0]       v_o,
  input logic             vd_o,
  input logic             busy_o,
  input logic             done_o,
  input logic             run_i,
  input logic [LEN_W-1:0] len_pos_i
);
  p_accept_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && step_cnt_i != '0 |=> busy_o);

  p_zero_cnt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && step_cnt_i == '0 |=> !busy_o);

  p_pairs_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> (v_o[0] == v_o[1]) && (v_o[3] == v_o[4])
              && $countones({v_o[5], v_o[3], v_o[2], v_o[0]}) == 2);

  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && len_pos_i != '0 |-> $stable(v_o));

  p_done_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  p_done_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_busy_in_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i |-> busy_o);

  p_vd_blank_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !vd_o);
endmodule

bind ccd_vsweep ccd_vsweep_chk #(.CNT_W(CNT_W), .LEN_W(LEN_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .step_cnt_i(step_cnt_i),
  .v_o       (v_o),
  .vd_o      (vd_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .run_i     (run_w),
  .len_pos_i (len_pos_w)
);

// File: tb/ccd_vsweep_tb.sv
module ccd_vsweep_tb_top;
  localparam int CNT_W = 10;
  localparam int LEN_W = 6;
  localparam int START_POS = 56;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hd_i = 1'b0, vd_i = 1'b1, start_i = 1'b0;
  logic [CNT_W-1:0] step_cnt_i = '0;
  logic [LEN_W-1:0] step_len_i = '0;
  logic [5:0] norm_v_i = '0;
  logic [5:0] v_o;
  logic vd_o, busy_o, done_o;

  always #2 clk = ~clk;

  ccd_vsweep #(.CNT_W(CNT_W), .LEN_W(LEN_W), .START_POS(START_POS)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .hd_i(hd_i), .vd_i(vd_i), .start_i(start_i),
    .step_cnt_i(step_cnt_i), .step_len_i(step_len_i), .norm_v_i(norm_v_i),
    .v_o(v_o), .vd_o(vd_o), .busy_o(busy_o), .done_o(done_o));

  typedef struct { logic [5:0] pat; int len; bit last; } item_t;
  item_t q[$];

  int checks = 0, errors = 0, cyc = 0, line_len = 100, bpos = 0;
  int sweeps_done = 0;
  bit full_chk = 0;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] pat_of(int s);
    case (s % 4)
      0: return 6'b000111;
      1: return 6'b011100;
      2: return 6'b111000;
      default: return 6'b100011;
    endcase
  endfunction

  // line position model
  always @(posedge clk) bpos <= hd_i ? 0 : bpos + 1;

  initial begin
    forever begin
      repeat (line_len - 1) @(negedge clk);
      hd_i = 1'b1;
      @(negedge clk);
      hd_i = 1'b0;
    end
  end

  // driver: expected items then start pulse
  task automatic push_sweep(int cnt, int len);
    int l = (len == 0) ? 1 : len;
    for (int s = 0; s < cnt * 4; s++) begin
      item_t it;
      it.pat = pat_of(s); it.len = l; it.last = (s == cnt * 4 - 1);
      q.push_back(it);
    end
  endtask

  task automatic pulse_start(int cnt, int len);
    step_cnt_i = CNT_W'(cnt); step_len_i = LEN_W'(len); start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_sweep();
    do @(negedge clk); while (v_o == norm_v_i);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0 && v_o != norm_v_i) begin
        item_t it;
        check(bpos == START_POS, "R2 start position", bpos, START_POS);
        do begin
          bit ok = 1;
          logic [5:0] bad = '0;
          it = q.pop_front();
          for (int i = 0; i < it.len; i++) begin
            if (v_o !== it.pat) begin ok = 0; bad = v_o; end
            @(negedge clk);
          end
          check(ok, "R3/R4 phase state", bad, it.pat);
        end while (!it.last);
        check(done_o === 1'b1 && busy_o === 1'b0, "R5 done/busy at end",
              {done_o, busy_o}, 2'b10);
        check(v_o == norm_v_i, "R8 handback", v_o, norm_v_i);
        if (full_chk) check(bpos == 0, "R5 full sweep spans 23 lines", bpos, 0);
        @(negedge clk);
        check(done_o === 1'b0, "R5 done single pulse", done_o, 0);
        sweeps_done++;
      end
    end
  end

  initial begin
    while (cyc < 190000) begin @(posedge clk); cyc++; end
    errors++;
    $display("FAIL watchdog actual=%0d expected<190000", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(busy_o == 0 && done_o == 0, "R1 reset idle", {busy_o, done_o}, 0);
    check(v_o == norm_v_i, "R8 reset pass", v_o, norm_v_i);
    check(vd_o == 1'b1, "R7 vd passes when idle", vd_o, 1);

    // basic sweep
    push_sweep(3, 2);
    pulse_start(3, 2);
    check(busy_o == 1'b1, "R1 busy after start", busy_o, 1);
    wait (sweeps_done == 1);

    // zero count ignored
    pulse_start(0, 5);
    check(busy_o == 1'b0, "R9 zero count", busy_o, 0);
    repeat (line_len + 5) @(negedge clk);
    check(busy_o == 1'b0 && v_o == norm_v_i, "R9 no sweep", {busy_o, v_o}, {1'b0, norm_v_i});

    // normal phases pass while waiting, vd blanked
    norm_v_i = 6'b101010;
    push_sweep(2, 3);
    pulse_start(2, 3);
    check(v_o == 6'b101010, "R8 pass during wait", v_o, 6'b101010);
    check(vd_o == 1'b0, "R7 vd blanked", vd_o, 0);
    wait (sweeps_done == 2);
    norm_v_i = 6'b000000;
    @(negedge clk);
    check(vd_o == 1'b1, "R7 vd restored", vd_o, 1);

    // start while busy ignored
    push_sweep(4, 3);
    pulse_start(4, 3);
    wait_sweep();
    repeat (9) @(negedge clk);
    pulse_start(1, 1);
    check(busy_o == 1'b1, "R6 busy kept", busy_o, 1);
    wait (sweeps_done == 3);

    // zero length treated as one
    push_sweep(2, 0);
    pulse_start(2, 0);
    wait (sweeps_done == 4);

    // start on last cycle ignored, start on done cycle accepted
    push_sweep(2, 2);
    pulse_start(2, 2);
    wait_sweep();
    repeat (15) @(negedge clk);
    step_cnt_i = CNT_W'(3); step_len_i = LEN_W'(1); start_i = 1'b1;
    @(negedge clk);
    check(done_o == 1'b1, "R10 done cycle reached", done_o, 1);
    push_sweep(1, 2);
    step_cnt_i = CNT_W'(1); step_len_i = LEN_W'(2);
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R10 accepted on done", busy_o, 1);
    wait (sweeps_done == 6);

    // full default sweep over 1848-clock lines
    line_len = 1848;
    repeat (2000) @(negedge clk);
    full_chk = 1;
    push_sweep(758, 14);
    pulse_start(758, 14);
    wait (sweeps_done == 7);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule